// File: doc/BRIEF.md
# Indexed Effective-Address Sequencer

This block computes the effective address of an indexed operand for an 8-bit processor with a 16-bit address space. A single postbyte is presented with a start strobe. The block decodes that byte and picks one of four 16-bit index registers. It adds an offset to that register, to the program counter, or to nothing. The offset comes from a short field inside the postbyte, from an accumulator, or from one or two extension bytes that it pulls from the instruction stream. The block then optionally follows a 16-bit pointer in memory.

For the auto-increment and auto-decrement forms, the block produces the updated index value and a write-back strobe for the register file. For each operand it also reports two numbers: the extra cycles the operand costs, and the extension bytes it consumed. The surrounding sequencer supplies the register values, the accumulators and the program counter that follows the postbyte. It then waits for the done pulse.

Top module: `idx_agen`

## Requirements
- R1: Postbyte bits 6:5 pick the index register: 00 selects `idx0`, 01 `idx1`, 10 `idx2`, 11 `idx3`. A write-back reports the same code on `wb_sel`.
- R2: With postbyte bit 7 clear, the address is the selected register plus bits 4:0 read as a two's-complement value (-16..15). This form fetches no extension byte, reports zero extra cycles, performs no memory read and asserts no write-back.
- R3: With bit 7 set, the mode field (bits 3:0) selects the form. Mode 0 and mode 1 return the old register value and write back the register plus 1 and plus 2 respectively. Mode 2 and mode 3 write back the register minus 1 and minus 2, and return that new value. All arithmetic wraps modulo 2^16.
- R4: Mode 4 returns the register unchanged. Mode 5 adds sign-extended `acc_b`, mode 6 adds sign-extended `acc_a`, and mode 11 adds the 16-bit value {`acc_a`,`acc_b`}.
- R5: Mode 8 consumes one extension byte and adds it sign-extended. Mode 9 consumes two bytes and adds them as a 16-bit word, with the first byte received taken as the high byte. `ext_used` reports the byte count.
- R6: Mode 12 (one byte, sign-extended) and mode 13 (two-byte word) add their offset to `pc_in` plus the number of extension bytes consumed, all modulo 2^16.
- R7: Mode 15 consumes two extension bytes and uses that word as the address. Modes 10 and 7 yield 0x0000, and mode 14 yields 0xFFFF.
- R8: In the long forms, postbyte bit 4 set requests indirection. The block reads the byte at the computed address as the high half and the byte at that address plus 1 (wrapping) as the low half. The resulting word becomes `ea`.
- R9: `extra_cycles` is 0 for the short form. For the long forms it is 1, or 2 for modes 1, 3, 9, 11 and 13.
- R10: After reset `busy`, `done`, `ext_req` and `mem_req` are low. `done` is a one-cycle pulse with `busy` low, and `wb_en` is only ever high with `done`. The postbyte and operands are captured at start, and `start` or postbyte changes while busy have no effect.
- R11: An extension byte is taken only in a cycle where `ext_req` and `ext_valid` are both high. A memory byte is taken only where `mem_req` and `mem_ready` are both high. While waiting, `mem_addr` holds steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address computation (sampled when idle) |
| postbyte | input | 8 | Indexed-mode postbyte |
| idx0 | input | 16 | Index register 0 |
| idx1 | input | 16 | Index register 1 |
| idx2 | input | 16 | Index register 2 |
| idx3 | input | 16 | Index register 3 |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| pc_in | input | 16 | Program counter just after the postbyte |
| ext_req | output | 1 | Requesting an extension byte |
| ext_valid | input | 1 | Extension byte present |
| ext_byte | input | 8 | Extension byte value |
| mem_req | output | 1 | Pointer byte read request |
| mem_addr | output | 16 | Pointer byte address |
| mem_ready | input | 1 | Read data present |
| mem_rdata | input | 8 | Read data |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 16 | Final effective address |
| wb_en | output | 1 | Index register write-back strobe |
| wb_sel | output | 2 | Register to write back |
| wb_value | output | 16 | Updated index register value |
| extra_cycles | output | 2 | Extra cycle count of the operand |
| ext_used | output | 2 | Extension bytes consumed |

## Verification
The start strobe is taken at one edge, and each extension byte and each pointer byte takes one further edge once its handshake partner is high. One more edge computes the sum, so with no stalls `done` is seen after 2 + bytes + 2·indirect edges. The bench drives every input half a cycle after an edge. It answers `ext_req` and `mem_req` in the cycle they are seen, counts the bytes it actually handed over, and samples `done` and its companions at falling edges. In the stall-free pass the exact edge count is compared with that formula. In the stalled passes, where handshake partners are withheld at pseudo-random cycles, only the values and the handshake counts are compared.

// File: rtl/idx_agen_pkg.sv
package idx_agen_pkg;

    localparam int ADDR_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int N_IDX   = 4;
    localparam int SEL_W   = $clog2(N_IDX);
    localparam int MODE_W  = 4;
    localparam int SHORT_W = 5;
    localparam int XCYC_W  = 2;
    localparam int NB_W    = 2;

    // Long-form mode codes
    localparam logic [MODE_W-1:0] MD_POST1 = 4'h0;
    localparam logic [MODE_W-1:0] MD_POST2 = 4'h1;
    localparam logic [MODE_W-1:0] MD_PRE1  = 4'h2;
    localparam logic [MODE_W-1:0] MD_PRE2  = 4'h3;
    localparam logic [MODE_W-1:0] MD_PLAIN = 4'h4;
    localparam logic [MODE_W-1:0] MD_ACCB  = 4'h5;
    localparam logic [MODE_W-1:0] MD_ACCA  = 4'h6;
    localparam logic [MODE_W-1:0] MD_EXT8  = 4'h8;
    localparam logic [MODE_W-1:0] MD_EXT16 = 4'h9;
    localparam logic [MODE_W-1:0] MD_ACCD  = 4'hB;
    localparam logic [MODE_W-1:0] MD_PC8   = 4'hC;
    localparam logic [MODE_W-1:0] MD_PC16  = 4'hD;
    localparam logic [MODE_W-1:0] MD_ONES  = 4'hE;
    localparam logic [MODE_W-1:0] MD_ABS   = 4'hF;

    typedef enum logic [2:0] {
        BASE_IDX, BASE_PC, BASE_ZERO, BASE_ONES, BASE_EXT
    } base_e;

    typedef enum logic [3:0] {
        OFS_NONE, OFS_SHORT, OFS_ACC_A, OFS_ACC_B, OFS_ACC_D,
        OFS_EXT8, OFS_EXT16, OFS_DEC1, OFS_DEC2
    } ofs_e;

    typedef enum logic [1:0] {
        UPD_INC1, UPD_INC2, UPD_DEC1, UPD_DEC2
    } upd_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_EXT, ST_CALC, ST_PTR_HI, ST_PTR_LO
    } state_e;

    typedef struct packed {
        logic [SEL_W-1:0]   rsel;
        base_e              base;
        ofs_e               ofs;
        logic [SHORT_W-1:0] short_ofs;
        logic [NB_W-1:0]    ext_bytes;
        logic               indirect;
        logic [XCYC_W-1:0]  extra;
        logic               upd_en;
        upd_e               upd;
    } decode_t;

    function automatic logic [ADDR_W-1:0] sext_short(input logic [SHORT_W-1:0] v);
        return {{(ADDR_W-SHORT_W){v[SHORT_W-1]}}, v};
    endfunction

    function automatic logic [ADDR_W-1:0] sext_byte(input logic [BYTE_W-1:0] v);
        return {{(ADDR_W-BYTE_W){v[BYTE_W-1]}}, v};
    endfunction

    // Modes that cost one cycle beyond the long-form base cycle
    function automatic logic costs_more(input logic [MODE_W-1:0] m);
        return (m == MD_POST2) || (m == MD_PRE2) || (m == MD_EXT16) ||
               (m == MD_ACCD)  || (m == MD_PC16);
    endfunction

endpackage

// File: rtl/idx_agen_decode.sv
module idx_agen_decode
    import idx_agen_pkg::*;
(
    input  logic [BYTE_W-1:0] postbyte,
    output decode_t           dec
);

    logic [MODE_W-1:0] mode;
    assign mode = postbyte[MODE_W-1:0];

    always_comb begin
        dec           = '0;
        dec.base      = BASE_IDX;
        dec.ofs       = OFS_NONE;
        dec.upd       = UPD_INC1;
        dec.rsel      = postbyte[6:5];
        if (!postbyte[7]) begin
            dec.ofs       = OFS_SHORT;
            dec.short_ofs = postbyte[SHORT_W-1:0];
        end else begin
            dec.indirect = postbyte[4];
            dec.extra    = costs_more(mode) ? XCYC_W'(2) : XCYC_W'(1);
            case (mode)
                MD_POST1: begin dec.upd_en = 1'b1; dec.upd = UPD_INC1; end
                MD_POST2: begin dec.upd_en = 1'b1; dec.upd = UPD_INC2; end
                MD_PRE1:  begin dec.upd_en = 1'b1; dec.upd = UPD_DEC1; dec.ofs = OFS_DEC1; end
                MD_PRE2:  begin dec.upd_en = 1'b1; dec.upd = UPD_DEC2; dec.ofs = OFS_DEC2; end
                MD_PLAIN: dec.ofs = OFS_NONE;
                MD_ACCB:  dec.ofs = OFS_ACC_B;
                MD_ACCA:  dec.ofs = OFS_ACC_A;
                MD_ACCD:  dec.ofs = OFS_ACC_D;
                MD_EXT8:  begin dec.ofs = OFS_EXT8;  dec.ext_bytes = NB_W'(1); end
                MD_EXT16: begin dec.ofs = OFS_EXT16; dec.ext_bytes = NB_W'(2); end
                MD_PC8:   begin dec.base = BASE_PC; dec.ofs = OFS_EXT8;  dec.ext_bytes = NB_W'(1); end
                MD_PC16:  begin dec.base = BASE_PC; dec.ofs = OFS_EXT16; dec.ext_bytes = NB_W'(2); end
                MD_ABS:   begin dec.base = BASE_EXT; dec.ext_bytes = NB_W'(2); end
                MD_ONES:  dec.base = BASE_ONES;
                default:  dec.base = BASE_ZERO;
            endcase
        end
    end

endmodule

// File: rtl/idx_agen_calc.sv
module idx_agen_calc
    import idx_agen_pkg::*;
(
    input  decode_t            dec,
    input  logic [ADDR_W-1:0]  idx_val,
    input  logic [ADDR_W-1:0]  pc_val,
    input  logic [BYTE_W-1:0]  acc_a,
    input  logic [BYTE_W-1:0]  acc_b,
    input  logic [ADDR_W-1:0]  ext_word,
    output logic [ADDR_W-1:0]  ea,
    output logic [ADDR_W-1:0]  upd_val
);

    logic [ADDR_W-1:0] pc_after;
    logic [ADDR_W-1:0] base_val;
    logic [ADDR_W-1:0] ofs_val;

    // PC-relative forms see the counter after the extension bytes
    assign pc_after = pc_val + ADDR_W'(dec.ext_bytes);

    always_comb begin
        case (dec.base)
            BASE_PC:   base_val = pc_after;
            BASE_ZERO: base_val = '0;
            BASE_ONES: base_val = '1;
            BASE_EXT:  base_val = ext_word;
            default:   base_val = idx_val;
        endcase
    end

    always_comb begin
        case (dec.ofs)
            OFS_SHORT: ofs_val = sext_short(dec.short_ofs);
            OFS_ACC_A: ofs_val = sext_byte(acc_a);
            OFS_ACC_B: ofs_val = sext_byte(acc_b);
            OFS_ACC_D: ofs_val = {acc_a, acc_b};
            OFS_EXT8:  ofs_val = sext_byte(ext_word[BYTE_W-1:0]);
            OFS_EXT16: ofs_val = ext_word;
            OFS_DEC1:  ofs_val = '1;
            OFS_DEC2:  ofs_val = {{(ADDR_W-1){1'b1}}, 1'b0};
            default:   ofs_val = '0;
        endcase
    end

    assign ea = base_val + ofs_val;

    always_comb begin
        case (dec.upd)
            UPD_INC2: upd_val = idx_val + ADDR_W'(2);
            UPD_DEC1: upd_val = idx_val - ADDR_W'(1);
            UPD_DEC2: upd_val = idx_val - ADDR_W'(2);
            default:  upd_val = idx_val + ADDR_W'(1);
        endcase
    end

endmodule

// File: rtl/idx_agen.sv
module idx_agen
    import idx_agen_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [BYTE_W-1:0]   postbyte,
    input  logic [ADDR_W-1:0]   idx0,
    input  logic [ADDR_W-1:0]   idx1,
    input  logic [ADDR_W-1:0]   idx2,
    input  logic [ADDR_W-1:0]   idx3,
    input  logic [BYTE_W-1:0]   acc_a,
    input  logic [BYTE_W-1:0]   acc_b,
    input  logic [ADDR_W-1:0]   pc_in,
    output logic                ext_req,
    input  logic                ext_valid,
    input  logic [BYTE_W-1:0]   ext_byte,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_ready,
    input  logic [BYTE_W-1:0]   mem_rdata,
    output logic                busy,
    output logic                done,
    output logic [ADDR_W-1:0]   ea,
    output logic                wb_en,
    output logic [SEL_W-1:0]    wb_sel,
    output logic [ADDR_W-1:0]   wb_value,
    output logic [XCYC_W-1:0]   extra_cycles,
    output logic [NB_W-1:0]     ext_used
);

    state_e            state;
    logic [BYTE_W-1:0] pb_q;
    logic [ADDR_W-1:0] reg_q;
    logic [BYTE_W-1:0] a_q, b_q;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] ext_q;
    logic [NB_W-1:0]   ext_cnt;
    logic [ADDR_W-1:0] ptr_q;
    logic [BYTE_W-1:0] hi_q;
    logic              wb_pend;

    logic [ADDR_W-1:0] idx_arr [N_IDX];
    logic [BYTE_W-1:0] dec_in;
    decode_t           dec;
    logic [ADDR_W-1:0] calc_ea;
    logic [ADDR_W-1:0] calc_upd;
    logic [NB_W-1:0]   ext_cnt_nx;

    assign idx_arr[0] = idx0;
    assign idx_arr[1] = idx1;
    assign idx_arr[2] = idx2;
    assign idx_arr[3] = idx3;

    // Live postbyte while idle so the first state choice needs no extra cycle
    assign dec_in = (state == ST_IDLE) ? postbyte : pb_q;

    idx_agen_decode u_decode (
        .postbyte (dec_in),
        .dec      (dec)
    );

    idx_agen_calc u_calc (
        .dec      (dec),
        .idx_val  (reg_q),
        .pc_val   (pc_q),
        .acc_a    (a_q),
        .acc_b    (b_q),
        .ext_word (ext_q),
        .ea       (calc_ea),
        .upd_val  (calc_upd)
    );

    assign ext_cnt_nx = ext_cnt + NB_W'(1);
    assign busy       = (state != ST_IDLE);
    assign ext_req    = (state == ST_EXT);
    assign mem_req    = (state == ST_PTR_HI) || (state == ST_PTR_LO);
    assign mem_addr   = (state == ST_PTR_LO) ? ptr_q + ADDR_W'(1) : ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            pb_q         <= '0;
            reg_q        <= '0;
            a_q          <= '0;
            b_q          <= '0;
            pc_q         <= '0;
            ext_q        <= '0;
            ext_cnt      <= '0;
            ptr_q        <= '0;
            hi_q         <= '0;
            wb_pend      <= 1'b0;
            done         <= 1'b0;
            ea           <= '0;
            wb_en        <= 1'b0;
            wb_sel       <= '0;
            wb_value     <= '0;
            extra_cycles <= '0;
            ext_used     <= '0;
        end else begin
            done  <= 1'b0;
            wb_en <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        pb_q    <= postbyte;
                        reg_q   <= idx_arr[postbyte[6:5]];
                        a_q     <= acc_a;
                        b_q     <= acc_b;
                        pc_q    <= pc_in;
                        ext_q   <= '0;
                        ext_cnt <= '0;
                        state   <= (dec.ext_bytes != '0) ? ST_EXT : ST_CALC;
                    end
                end
                ST_EXT: begin
                    if (ext_valid) begin
                        ext_q   <= {ext_q[ADDR_W-BYTE_W-1:0], ext_byte};
                        ext_cnt <= ext_cnt_nx;
                        if (ext_cnt_nx == dec.ext_bytes) state <= ST_CALC;
                    end
                end
                ST_CALC: begin
                    ptr_q        <= calc_ea;
                    wb_pend      <= dec.upd_en;
                    wb_sel       <= dec.rsel;
                    wb_value     <= calc_upd;
                    extra_cycles <= dec.extra;
                    ext_used     <= ext_cnt;
                    if (dec.indirect) begin
                        state <= ST_PTR_HI;
                    end else begin
                        ea    <= calc_ea;
                        done  <= 1'b1;
                        wb_en <= dec.upd_en;
                        state <= ST_IDLE;
                    end
                end
                ST_PTR_HI: begin
                    if (mem_ready) begin
                        hi_q  <= mem_rdata;
                        state <= ST_PTR_LO;
                    end
                end
                ST_PTR_LO: begin
                    if (mem_ready) begin
                        ea    <= {hi_q, mem_rdata};
                        done  <= 1'b1;
                        wb_en <= wb_pend;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: completion is a single-cycle pulse and leaves the block idle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R10 / R3: write-back strobe only accompanies completion
    p_wb_with_done_r3: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> done);
    // R11: a pending read keeps its request and address
    p_mem_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
    // R11: a pending extension request is not withdrawn
    p_ext_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (ext_req && !ext_valid) |=> ext_req);
    // R8: the low pointer byte follows the high byte address
    p_ptr_next_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PTR_LO && $past(state) == ST_PTR_HI) |-> mem_addr == $past(mem_addr) + ADDR_W'(1));
    // R9: extra cycle count never exceeds two
    p_extra_range_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (extra_cycles != 2'd3));
    // R11: never ask for bytes and memory at once
    p_req_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(ext_req && mem_req));

endmodule

// File: tb/idx_agen_tb.sv
module idx_agen_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [7:0]  postbyte;
    logic [15:0] idx0, idx1, idx2, idx3;
    logic [7:0]  acc_a, acc_b;
    logic [15:0] pc_in;
    logic        ext_req, ext_valid;
    logic [7:0]  ext_byte;
    logic        mem_req, mem_ready;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        busy, done, wb_en;
    logic [15:0] ea, wb_value;
    logic [1:0]  wb_sel, extra_cycles, ext_used;

    int tests = 0;
    int fails = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    idx_agen u_dut (
        .clk(clk), .rst(rst), .start(start), .postbyte(postbyte),
        .idx0(idx0), .idx1(idx1), .idx2(idx2), .idx3(idx3),
        .acc_a(acc_a), .acc_b(acc_b), .pc_in(pc_in),
        .ext_req(ext_req), .ext_valid(ext_valid), .ext_byte(ext_byte),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .ea(ea), .wb_en(wb_en), .wb_sel(wb_sel),
        .wb_value(wb_value), .extra_cycles(extra_cycles), .ext_used(ext_used)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] step(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    function automatic logic [7:0] mv(input logic [15:0] a);
        return a[15:8] ^ {a[6:0], a[7]} ^ 8'hA5;
    endfunction

    function automatic logic [15:0] sx8(input logic [7:0] v);
        return {{8{v[7]}}, v};
    endfunction

    function automatic string tag_of(input logic [7:0] pb);
        if (!pb[7]) return "R2";
        if (pb[4]) return "R8";
        case (pb[3:0])
            4'h0, 4'h1, 4'h2, 4'h3: return "R3";
            4'h4, 4'h5, 4'h6, 4'hB: return "R4";
            4'h8, 4'h9:             return "R5";
            4'hC, 4'hD:             return "R6";
            default:                return "R7";
        endcase
    endfunction

    task automatic model(input logic [7:0] pb, input logic [15:0] r, input logic [15:0] pcv,
                         input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] e0, input logic [7:0] e1,
                         output logic [15:0] ea_pre, output int nb, output logic ind,
                         output logic [1:0] xc, output logic wb, output logic [15:0] wbv);
        logic [15:0] pcu;
        logic [3:0]  m;
        m = pb[3:0];
        nb = 0; ind = 1'b0; xc = 2'd0; wb = 1'b0; wbv = 16'h0;
        if (!pb[7]) begin
            ea_pre = r + {{11{pb[4]}}, pb[4:0]};
        end else begin
            ind = pb[4];
            if (m == 4'h8 || m == 4'hC) nb = 1;
            if (m == 4'h9 || m == 4'hD || m == 4'hF) nb = 2;
            pcu = pcv + 16'(nb);
            xc = (m == 4'h1 || m == 4'h3 || m == 4'h9 || m == 4'hB || m == 4'hD) ? 2'd2 : 2'd1;
            wb = (m <= 4'h3);
            case (m)
                4'h0: begin ea_pre = r;        wbv = r + 16'd1; end
                4'h1: begin ea_pre = r;        wbv = r + 16'd2; end
                4'h2: begin ea_pre = r - 16'd1; wbv = r - 16'd1; end
                4'h3: begin ea_pre = r - 16'd2; wbv = r - 16'd2; end
                4'h4: ea_pre = r;
                4'h5: ea_pre = r + sx8(b);
                4'h6: ea_pre = r + sx8(a);
                4'h8: ea_pre = r + sx8(e0);
                4'h9: ea_pre = r + {e0, e1};
                4'hB: ea_pre = r + {a, b};
                4'hC: ea_pre = pcu + sx8(e0);
                4'hD: ea_pre = pcu + {e0, e1};
                4'hE: ea_pre = 16'hFFFF;
                4'hF: ea_pre = {e0, e1};
                default: ea_pre = 16'h0000;
            endcase
        end
    endtask

    task automatic run_one(input logic [7:0] pb, input int pass);
        logic [15:0] regs [4];
        logic [15:0] ea_pre, ea_exp, wbv, addr_seen [2];
        logic [7:0]  e0, e1;
        logic        ind, wb, off_ext, off_mem, got, go;
        logic [1:0]  xc;
        int          nb, edges, bidx, nptr;
        string       tg;
        if (pass == 0) begin
            regs[0] = 16'h0000; regs[1] = 16'hFFFF; regs[2] = 16'h8000; regs[3] = 16'h7FFF;
            acc_a = 8'h80; acc_b = 8'h7F; pc_in = 16'hFFFE;
        end else if (pass == 1) begin
            regs[0] = 16'h1234; regs[1] = 16'h00FF; regs[2] = 16'hFF00; regs[3] = 16'hABCD;
            acc_a = 8'h01; acc_b = 8'hFF; pc_in = 16'h4000;
        end else begin
            for (int k = 0; k < 4; k++) begin lfsr = step(lfsr); regs[k] = lfsr; end
            lfsr = step(lfsr); acc_a = lfsr[7:0]; acc_b = lfsr[15:8];
            lfsr = step(lfsr); pc_in = lfsr;
        end
        lfsr = step(lfsr); e0 = lfsr[7:0]; e1 = lfsr[15:8];
        idx0 = regs[0]; idx1 = regs[1]; idx2 = regs[2]; idx3 = regs[3];
        model(pb, regs[pb[6:5]], pc_in, acc_a, acc_b, e0, e1, ea_pre, nb, ind, xc, wb, wbv);
        ea_exp = ind ? {mv(ea_pre), mv(ea_pre + 16'd1)} : ea_pre;
        tg = tag_of(pb);

        postbyte = pb; start = 1'b1; ext_valid = 1'b0; mem_ready = 1'b0;
        edges = 0; bidx = 0; nptr = 0; got = 1'b0; off_ext = 1'b0; off_mem = 1'b0;
        addr_seen[0] = 16'h0; addr_seen[1] = 16'h0;
        while (!got && edges < 200) begin
            @(negedge clk);
            edges++;
            if (off_ext) bidx++;
            if (off_mem) nptr++;
            if (pass == 2 && edges == 1) postbyte = ~pb;  // R10: change while busy
            if (pass != 2) start = 1'b0;
            if (done) begin
                got = 1'b1; start = 1'b0; ext_valid = 1'b0; mem_ready = 1'b0;
            end else begin
                lfsr = step(lfsr);
                go = (pass == 0) ? 1'b1 : lfsr[0];
                off_ext = ext_req && go;
                ext_valid = off_ext;
                ext_byte = (bidx == 0) ? e0 : e1;
                off_mem = mem_req && go;
                mem_ready = off_mem;
                mem_rdata = mv(mem_addr);
                if (off_mem && nptr < 2) addr_seen[nptr] = mem_addr;
            end
        end
        chk(got, "R10", "done seen", 32'(got), 32'd1);
        chk(ea == ea_exp, tg, $sformatf("ea pb=%02h", pb), 32'(ea), 32'(ea_exp));
        chk(extra_cycles == xc, "R9", $sformatf("extra pb=%02h", pb), 32'(extra_cycles), 32'(xc));
        chk(ext_used == 2'(nb) && bidx == nb, "R5", $sformatf("bytes pb=%02h", pb), 32'(bidx), 32'(nb));
        chk(wb_en == wb, "R3", $sformatf("wb_en pb=%02h", pb), 32'(wb_en), 32'(wb));
        if (wb) begin
            chk(wb_value == wbv, "R3", $sformatf("wb_value pb=%02h", pb), 32'(wb_value), 32'(wbv));
            chk(wb_sel == pb[6:5], "R1", $sformatf("wb_sel pb=%02h", pb), 32'(wb_sel), 32'(pb[6:5]));
        end
        chk(nptr == (ind ? 2 : 0), "R8", $sformatf("reads pb=%02h", pb), 32'(nptr), ind ? 32'd2 : 32'd0);
        if (ind) begin
            chk(addr_seen[0] == ea_pre && addr_seen[1] == ea_pre + 16'd1, "R8",
                $sformatf("ptr addr pb=%02h", pb), {addr_seen[0], addr_seen[1]},
                {ea_pre, ea_pre + 16'd1});
        end
        if (pass == 0) begin
            chk(edges == 2 + nb + (ind ? 2 : 0), "R11", $sformatf("latency pb=%02h", pb),
                32'(edges), 32'(2 + nb + (ind ? 2 : 0)));
        end
        @(negedge clk);
        chk(!done && !wb_en && !busy, "R10", "pulse ends", {done, wb_en, busy}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; postbyte = 8'h00; ext_valid = 1'b0; ext_byte = 8'h00;
        mem_ready = 1'b0; mem_rdata = 8'h00; acc_a = 8'h00; acc_b = 8'h00; pc_in = 16'h0;
        idx0 = 16'h0; idx1 = 16'h0; idx2 = 16'h0; idx3 = 16'h0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !ext_req && !mem_req, "R10", "reset state",
            {busy, done, ext_req, mem_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        for (int pass = 0; pass < 3; pass++) begin
            for (int p = 0; p < 256; p++) begin
                run_one(8'(p), pass);
            end
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule